// File: doc/BRIEF.md
# Dual-Processor Mailbox Controller

This block lets two processors on one chip signal each other through a shared register space. An application processor reaches the block through one APB slave port, and a microcontroller through a second APB slave port. Both ports see the same registers. In each direction there is a bank of message slots. Each slot holds a command word and a data word. Each slot also has a pending flag, and that flag drives an interrupt line towards the receiving processor. A sender posts a message in two writes: first the command word, then the data word. The write to the data word raises the flag. The receiver enables the interrupts it wants, reads the slot, and clears the flag by writing a one to its status bit.

Alongside the slots sits a bank of software locks with test-and-set semantics. A read from a lock both tests it and takes it. Only one port is served in any cycle, so two processors that race for the same lock cannot both win. When both ports present an access phase in the same cycle, the application-processor port completes first. The other port is stretched by one wait state.

Top module: `dual_mailbox`

## Requirements
- R1: Register offsets. In the A-to-B bank, enable is at 0x00 and status at 0x04. Slot x has its command word at 0x08+8x and its data word at 0x0C+8x. The B-to-A bank uses the same layout shifted by 0x28. Each 32-bit command and data word reads back the last value written to it.
- R2: Writing a slot's data word sets that slot's status bit; status bit x is bit x of the status register. Writing a command word leaves status unchanged.
- R3: `irq_to_b[x]` is high exactly when A-to-B status bit x and enable bit x are both 1. `irq_to_a[x]` does the same for the B-to-A bank. The line changes in the cycle after the write that changes status or enable.
- R4: Writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R5: Enable registers are read/write in bits [3:0]. Bits [31:4] read as zero whatever was written to them.
- R6: Reading lock x at 0x100+8x returns 0 and takes the lock when the lock is free. It returns 1 when the lock is already held. Both ports see the same locks.
- R7: Writing 0 to a lock frees it. Writing any nonzero value to a lock leaves it unchanged.
- R8: When both ports are in an access phase in the same cycle, port A completes with PREADY high. Port B sees PREADY low and completes in the next cycle. As a result, two simultaneous reads of one free lock return 0 to A and 1 to B, and two simultaneous writes to one register leave B's value in it.
- R9: An access that does not hit a register asserts PSLVERR and reads as 0. This covers offsets beyond the banks, offsets between locks, and addresses that are not word aligned. A write to such an address changes no register.
- R10: After reset every register, lock and interrupt line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_psel | input | 1 | Port A select |
| a_penable | input | 1 | Port A access phase |
| a_pwrite | input | 1 | Port A write (1) or read (0) |
| a_paddr | input | ADDR_W | Port A byte address |
| a_pwdata | input | 32 | Port A write data |
| a_prdata | output | 32 | Port A read data |
| a_pready | output | 1 | Port A transfer complete |
| a_pslverr | output | 1 | Port A error response |
| b_psel | input | 1 | Port B select |
| b_penable | input | 1 | Port B access phase |
| b_pwrite | input | 1 | Port B write (1) or read (0) |
| b_paddr | input | ADDR_W | Port B byte address |
| b_pwdata | input | 32 | Port B write data |
| b_prdata | output | 32 | Port B read data |
| b_pready | output | 1 | Port B transfer complete, low while held |
| b_pslverr | output | 1 | Port B error response |
| irq_to_a | output | NUM_SLOTS | Per-slot interrupts from the B-to-A bank |
| irq_to_b | output | NUM_SLOTS | Per-slot interrupts from the A-to-B bank |

## Verification
The bench builds the block with its default values: a 12-bit address, four slots per direction and 32 locks. With these values the real register map is reachable, including the last data word of each bank, lock 31 at 0x1F8, and the unmapped gaps between locks and past the second bank. Four slots give room to post in one slot while another slot stays idle. The bench runs both ports in parallel to provoke the same-cycle collision on a lock and on a command word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    // byte distance between consecutive slots or locks
    localparam int STRIDE = 8;
    // offset of the first slot inside a bank (after enable and status)
    localparam int SLOT_OFS = 8;
endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_acc,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  word_t             a_wdata,
    input  logic              b_acc,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  word_t             b_wdata,
    output logic              gnt_a,
    output logic              gnt_b,
    output logic              acc_vld,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output word_t             acc_wdata
);
    // fixed priority: port A wins every collision
    always_comb begin
        gnt_a     = a_acc;
        gnt_b     = b_acc & ~a_acc;
        acc_vld   = gnt_a | gnt_b;
        acc_wr    = gnt_a ? a_wr    : b_wr;
        acc_addr  = gnt_a ? a_addr  : b_addr;
        acc_wdata = gnt_a ? a_wdata : b_wdata;
    end

    // a held B access completes once A leaves its access phase
    assert_b_served_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_acc && b_acc) ##1 (b_acc && !a_acc) |-> gnt_b);
endmodule

// File: rtl/mbx_dir.sv
module mbx_dir
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    off,
    input  word_t                wdata,
    output word_t                rdata,
    output logic                 hit,
    output logic [NUM_SLOTS-1:0] irq
);
    localparam int SPAN  = SLOT_OFS + STRIDE * NUM_SLOTS;
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0]         en;
        logic [NUM_SLOTS-1:0]         st;
        logic [NUM_SLOTS-1:0][WORD_W-1:0] cmd;
        logic [NUM_SLOTS-1:0][WORD_W-1:0] dat;
    } bank_t;

    bank_t bank_d, bank_q;

    logic              is_en, is_st, is_slot, is_dat;
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  idx;
    logic [NUM_SLOTS-1:0] slot_hot;

    always_comb begin
        rel      = off - ADDR_W'(SLOT_OFS);
        is_en    = (off == '0);
        is_st    = (off == ADDR_W'(4));
        is_slot  = (off >= ADDR_W'(SLOT_OFS)) && (off < ADDR_W'(SPAN)) && (off[1:0] == 2'b00);
        is_dat   = rel[2];
        idx      = rel[3 +: IDX_W];
        slot_hot = '0;
        if (is_slot) slot_hot[idx] = 1'b1;
        hit      = is_en | is_st | is_slot;
    end

    always_comb begin
        bank_d = bank_q;
        rdata  = '0;
        if (is_en)        rdata = word_t'(bank_q.en);
        else if (is_st)   rdata = word_t'(bank_q.st);
        else if (is_slot) rdata = is_dat ? bank_q.dat[idx] : bank_q.cmd[idx];
        if (sel && wr) begin
            if (is_en) bank_d.en = wdata[NUM_SLOTS-1:0];
            if (is_st) bank_d.st = bank_q.st & ~wdata[NUM_SLOTS-1:0];
            if (is_slot && !is_dat) bank_d.cmd[idx] = wdata;
            if (is_slot && is_dat) begin
                bank_d.dat[idx] = wdata;
                bank_d.st[idx]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign irq = bank_q.st & bank_q.en;

    assert_post_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && is_slot && is_dat) |=> ((bank_q.st & $past(slot_hot)) != '0));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && is_st) |=> ((bank_q.st & $past(wdata[NUM_SLOTS-1:0])) == '0));

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> $stable(bank_q.st));
endmodule

// File: rtl/mbx_locks.sv
module mbx_locks
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LOCKS = 32,
    parameter int LOCK_BASE = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output word_t             rdata,
    output logic              hit
);
    localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;
    localparam int LIMIT = LOCK_BASE + STRIDE * NUM_LOCKS;

    typedef struct packed {
        logic [NUM_LOCKS-1:0] held;
    } lock_t;

    lock_t             lk_d, lk_q;
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  idx;
    logic [NUM_LOCKS-1:0] lock_hot;

    always_comb begin
        rel      = addr - ADDR_W'(LOCK_BASE);
        idx      = rel[3 +: IDX_W];
        hit      = (addr >= ADDR_W'(LOCK_BASE)) && (addr < ADDR_W'(LIMIT)) && (addr[2:0] == 3'b000);
        lock_hot = '0;
        if (hit) lock_hot[idx] = 1'b1;
        rdata    = hit ? word_t'(lk_q.held[idx]) : '0;
        lk_d     = lk_q;
        if (sel && hit) begin
            if (!wr)              lk_d.held[idx] = 1'b1;
            else if (wdata == '0) lk_d.held[idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assert_read_takes_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && hit && !wr) |=> ((lk_q.held & $past(lock_hot)) != '0));

    assert_locks_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(lk_q.held));
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    parameter int NUM_LOCKS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_psel,
    input  logic                 a_penable,
    input  logic                 a_pwrite,
    input  logic [ADDR_W-1:0]    a_paddr,
    input  logic [31:0]          a_pwdata,
    output logic [31:0]          a_prdata,
    output logic                 a_pready,
    output logic                 a_pslverr,
    input  logic                 b_psel,
    input  logic                 b_penable,
    input  logic                 b_pwrite,
    input  logic [ADDR_W-1:0]    b_paddr,
    input  logic [31:0]          b_pwdata,
    output logic [31:0]          b_prdata,
    output logic                 b_pready,
    output logic                 b_pslverr,
    output logic [NUM_SLOTS-1:0] irq_to_a,
    output logic [NUM_SLOTS-1:0] irq_to_b
);
    localparam int SPAN   = SLOT_OFS + STRIDE * NUM_SLOTS;
    localparam int N_BANK = 2;  // bank 0: A to B, bank 1: B to A

    logic              gnt_a, gnt_b, acc_vld, acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    word_t             acc_wdata;

    mbx_arbiter #(.ADDR_W(ADDR_W)) i_arb (
        .clk(clk), .rst_n(rst_n),
        .a_acc(a_psel & a_penable), .a_wr(a_pwrite), .a_addr(a_paddr), .a_wdata(a_pwdata),
        .b_acc(b_psel & b_penable), .b_wr(b_pwrite), .b_addr(b_paddr), .b_wdata(b_pwdata),
        .gnt_a(gnt_a), .gnt_b(gnt_b), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata)
    );

    word_t                     bank_rd [N_BANK];
    logic [N_BANK-1:0]         bank_hit;
    logic [N_BANK-1:0]         bank_in;
    logic [NUM_SLOTS-1:0]      bank_irq [N_BANK];

    for (genvar d = 0; d < N_BANK; d++) begin : g_bank
        logic [ADDR_W-1:0] boff;
        assign boff       = acc_addr - ADDR_W'(d * SPAN);
        assign bank_in[d] = (boff < ADDR_W'(SPAN));
        mbx_dir #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) i_dir (
            .clk(clk), .rst_n(rst_n),
            .sel(acc_vld & bank_in[d]), .wr(acc_wr), .off(boff), .wdata(acc_wdata),
            .rdata(bank_rd[d]), .hit(bank_hit[d]), .irq(bank_irq[d])
        );
    end

    word_t lock_rd;
    logic  lock_hit;

    mbx_locks #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .LOCK_BASE('h100)) i_locks (
        .clk(clk), .rst_n(rst_n),
        .sel(acc_vld), .wr(acc_wr), .addr(acc_addr), .wdata(acc_wdata),
        .rdata(lock_rd), .hit(lock_hit)
    );

    logic  mapped;
    word_t rd_mux;

    always_comb begin
        mapped = lock_hit;
        rd_mux = lock_rd;
        for (int d = 0; d < N_BANK; d++) begin
            if (bank_in[d] && bank_hit[d]) begin
                mapped = 1'b1;
                rd_mux = bank_rd[d];
            end
        end
        a_pready  = 1'b1;
        b_pready  = ~gnt_a;
        a_prdata  = (gnt_a && mapped) ? rd_mux : '0;
        b_prdata  = (gnt_b && mapped) ? rd_mux : '0;
        a_pslverr = gnt_a & ~mapped;
        b_pslverr = gnt_b & ~mapped;
    end

    assign irq_to_b = bank_irq[0];
    assign irq_to_a = bank_irq[1];
endmodule

// File: tb/test_dual_mailbox.sv
module test_dual_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          a_psel = 0, a_penable = 0, a_pwrite = 0;
    logic [AW-1:0] a_paddr = '0;
    logic [31:0]   a_pwdata = '0;
    logic [31:0]   a_prdata;
    logic          a_pready, a_pslverr;
    logic          b_psel = 0, b_penable = 0, b_pwrite = 0;
    logic [AW-1:0] b_paddr = '0;
    logic [31:0]   b_pwdata = '0;
    logic [31:0]   b_prdata;
    logic          b_pready, b_pslverr;
    logic [3:0]    irq_to_a, irq_to_b;

    dual_mailbox i_dual_mailbox (
        .clk(clk), .rst_n(rst_n),
        .a_psel(a_psel), .a_penable(a_penable), .a_pwrite(a_pwrite), .a_paddr(a_paddr),
        .a_pwdata(a_pwdata), .a_prdata(a_prdata), .a_pready(a_pready), .a_pslverr(a_pslverr),
        .b_psel(b_psel), .b_penable(b_penable), .b_pwrite(b_pwrite), .b_paddr(b_paddr),
        .b_pwdata(b_pwdata), .b_prdata(b_prdata), .b_pready(b_pready), .b_pslverr(b_pslverr),
        .irq_to_a(irq_to_a), .irq_to_b(irq_to_b)
    );

    typedef struct {
        logic [31:0] data;
        logic        err;
        bit          chk_data;
        string       tag;
    } exp_t;

    exp_t q_a[$];
    exp_t q_b[$];
    exp_t ea, eb;
    int   total = 0;
    int   bad = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    // driver: one APB transfer on the chosen port; expectation pushed at setup
    task automatic xfer(input bit pb, input bit wr, input logic [AW-1:0] addr,
                        input logic [31:0] wd, input logic [31:0] expd,
                        input bit experr, input bit chk, input string tag);
        exp_t e;
        e.data = expd; e.err = experr; e.chk_data = chk; e.tag = tag;
        @(posedge clk); #1;
        if (pb) begin
            q_b.push_back(e);
            b_psel = 1; b_penable = 0; b_pwrite = wr; b_paddr = addr; b_pwdata = wd;
        end else begin
            q_a.push_back(e);
            a_psel = 1; a_penable = 0; a_pwrite = wr; a_paddr = addr; a_pwdata = wd;
        end
        @(posedge clk); #1;
        if (pb) b_penable = 1; else a_penable = 1;
        forever begin
            @(negedge clk);
            if (pb ? b_pready : a_pready) break;
        end
        @(posedge clk); #1;
        if (pb) begin b_psel = 0; b_penable = 0; end
        else    begin a_psel = 0; a_penable = 0; end
    endtask

    task automatic wr_a(input logic [AW-1:0] addr, input logic [31:0] d, input string tag);
        xfer(0, 1, addr, d, 0, 0, 0, tag);
    endtask
    task automatic wr_b(input logic [AW-1:0] addr, input logic [31:0] d, input string tag);
        xfer(1, 1, addr, d, 0, 0, 0, tag);
    endtask
    task automatic rd_a(input logic [AW-1:0] addr, input logic [31:0] e, input string tag);
        xfer(0, 0, addr, 0, e, 0, 1, tag);
    endtask
    task automatic rd_b(input logic [AW-1:0] addr, input logic [31:0] e, input string tag);
        xfer(1, 0, addr, 0, e, 0, 1, tag);
    endtask

    // monitor: pops expectations as transfers complete
    always @(negedge clk) begin
        if (a_psel && a_penable && b_psel && b_penable)
            check(b_pready == 1'b0, "R8 port B held on collision", 32'(b_pready), 32'd0);
        if (a_psel && a_penable && a_pready) begin
            if (q_a.size() == 0) check(0, "scoreboard A empty", 0, 0);
            else begin
                ea = q_a.pop_front();
                check(a_pslverr == ea.err, {ea.tag, " (A pslverr)"}, 32'(a_pslverr), 32'(ea.err));
                if (ea.chk_data) check(a_prdata == ea.data, ea.tag, a_prdata, ea.data);
            end
        end
        if (b_psel && b_penable && b_pready) begin
            if (q_b.size() == 0) check(0, "scoreboard B empty", 0, 0);
            else begin
                eb = q_b.pop_front();
                check(b_pslverr == eb.err, {eb.tag, " (B pslverr)"}, 32'(b_pslverr), 32'(eb.err));
                if (eb.chk_data) check(b_prdata == eb.data, eb.tag, b_prdata, eb.data);
            end
        end
    end

    task automatic chk_irq(input logic [3:0] ea4, input logic [3:0] eb4, input string tag);
        @(negedge clk);
        check(irq_to_a == ea4, {tag, " irq_to_a"}, 32'(irq_to_a), 32'(ea4));
        check(irq_to_b == eb4, {tag, " irq_to_b"}, 32'(irq_to_b), 32'(eb4));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10: reset state
        chk_irq(4'h0, 4'h0, "R10 reset");
        rd_a(12'h000, 0, "R10 enable A2B");
        rd_a(12'h004, 0, "R10 status A2B");
        rd_b(12'h02C, 0, "R10 status B2A");
        rd_b(12'h030, 0, "R10 cmd B2A slot0");
        rd_a(12'h100, 0, "R10 lock0 free");
        wr_a(12'h100, 0, "R10 release lock0");

        // R1/R2: post to A2B slot 2
        wr_a(12'h018, 32'hCAFE0002, "R1 cmd write");
        rd_a(12'h004, 0, "R2 cmd write leaves status");
        wr_a(12'h01C, 32'h00001234, "R1 data write");
        rd_a(12'h004, 32'h4, "R2 data write sets flag");
        rd_b(12'h018, 32'hCAFE0002, "R1 cmd readback");
        rd_b(12'h01C, 32'h00001234, "R1 data readback");
        wr_b(12'h04C, 32'h77, "R1 B2A slot3 data");
        rd_a(12'h02C, 32'h8, "R2 B2A slot3 flag");
        rd_a(12'h04C, 32'h77, "R1 B2A slot3 readback");

        // R3/R5: enables
        chk_irq(4'h0, 4'h0, "R3 disabled");
        wr_b(12'h000, 32'hFFFFFFFF, "R5 enable write");
        rd_b(12'h000, 32'hF, "R5 enable upper zero");
        chk_irq(4'h0, 4'h4, "R3 A2B irq");
        wr_a(12'h028, 32'h1, "R3 B2A enable slot0 only");
        chk_irq(4'h0, 4'h4, "R3 enable without flag");
        wr_a(12'h028, 32'h8, "R3 B2A enable slot3");
        chk_irq(4'h8, 4'h4, "R3 B2A irq");

        // R4: write-1-to-clear
        wr_b(12'h004, 32'h0, "R4 zero write");
        rd_b(12'h004, 32'h4, "R4 zero keeps flag");
        wr_b(12'h004, 32'hB, "R4 other bits");
        rd_b(12'h004, 32'h4, "R4 other bits keep flag");
        wr_b(12'h004, 32'h4, "R4 clear");
        rd_b(12'h004, 32'h0, "R4 cleared");
        chk_irq(4'h8, 4'h0, "R4 irq drops");

        // R6/R7: locks
        rd_a(12'h128, 0, "R6 lock5 free take");
        rd_a(12'h128, 1, "R6 lock5 held");
        rd_b(12'h128, 1, "R6 lock5 held seen by B");
        rd_b(12'h1F8, 0, "R6 lock31 free");
        wr_a(12'h128, 32'h1, "R7 nonzero write");
        rd_a(12'h128, 1, "R7 nonzero ignored");
        wr_b(12'h128, 32'h0, "R7 release");
        rd_a(12'h128, 0, "R7 released");
        rd_b(12'h128, 1, "R7 retaken");

        // R8: collisions
        fork
            rd_a(12'h140, 0, "R8 A wins lock8");
            rd_b(12'h140, 1, "R8 B loses lock8");
        join
        fork
            wr_a(12'h008, 32'h11, "R8 A write");
            wr_b(12'h008, 32'h22, "R8 B write");
        join
        rd_a(12'h008, 32'h22, "R8 B write lands last");

        // R9: unmapped
        xfer(0, 0, 12'h104, 0, 0, 1, 1, "R9 gap between locks");
        xfer(1, 0, 12'h050, 0, 0, 1, 1, "R9 past B2A bank");
        xfer(0, 0, 12'h002, 0, 0, 1, 1, "R9 unaligned");
        xfer(0, 1, 12'h00D, 32'h55, 0, 1, 0, "R9 unaligned write");
        rd_a(12'h004, 0, "R9 status untouched");
        rd_a(12'h00C, 0, "R9 data untouched");
        rd_b(12'h100, 0, "R9 lock0 untouched");

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule